// File: doc/BRIEF.md
# Host Bus Grant Arbiter

This block decides which agent may drive a 32-bit shared parallel bus next. The agents are one internal master and up to `N_EXT` external masters, each with its own active-low request line. The block returns exactly one active-low grant at a time. When the bus goes idle, or when the current owner drops its request, the grant may move to another agent. When nobody asks for the bus, the grant rests on the internal master.

A 3-bit mode code sets the behaviour. The block captures the code once after each reset and keeps it until the next reset. The code chooses one of four behaviours:

- fixed-priority arbitration;
- round-robin arbitration;
- a pass-through mode in which arbitration happens elsewhere;
- an idle state in which no grant is ever issued.

In pass-through mode, the block drives every request pin. Pin 0 carries the internal master's request out to the outside arbiter, and the remaining pins sit high. The internal master's grant then follows the grant returned by the outside arbiter.

Top module: `bus_grant_arbiter`

## Requirements
- R1: While `rst_n` is low, every pin of `gnt_n` is high, `own_gnt_n` is high and `req_n_oe` is all zeros.
- R2: `mode_cfg` is captured on the first rising clock edge after `rst_n` goes high. Later changes to `mode_cfg` have no effect until the next reset.
- R3: At most one grant (across `own_gnt_n` and all of `gnt_n`) is low at any time.
- R4: A request change applied between edges appears at the grant outputs after the second following rising edge: one edge samples the request, the next edge updates the grant.
- R5: Mode code 4 selects fixed priority. The internal master wins over every external line, and a lower line index wins over a higher one.
- R6: Mode code 5 selects round robin over agents ordered internal, line 0 … line N_EXT-1, wrapping. The search starts just after the agent granted most recently, and the first grant after reset goes to the internal master.
- R7: A grant is held while the sampled bus is busy (`frame_n` or `irdy_n` low) and the owner still requests. It may move only when the sampled bus is idle or the owner's sampled request is released.
- R8: In mode 4 or 5, when no sampled request is active, the grant goes to the internal master (`own_gnt_n` low).
- R9: Mode code 3 (pass-through) produces the following, combinationally:
  - every request pin is driven (`req_n_oe` all ones);
  - `req_n_out[0]` equals `own_req_n` and the other `req_n_out` bits are high;
  - all `gnt_n` are high;
  - `own_gnt_n` equals `ext_gnt_n`.
- R10: Any mode code other than 3, 4 or 5 (codes 6 and 7 included) keeps every grant high and leaves the request pins undriven (`req_n_oe` zero), whatever the requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | 3 | Mode code, captured after reset |
| own_req_n | input | 1 | Internal master request, active low |
| own_gnt_n | output | 1 | Internal master grant, active low |
| req_n_in | input | N_EXT | Request pin levels as seen at the pads |
| req_n_out | output | N_EXT | Request pin drive values |
| req_n_oe | output | N_EXT | Request pin drive enables, 1 = drive |
| gnt_n | output | N_EXT | External master grants, active low |
| ext_gnt_n | input | 1 | Grant from an outside arbiter, active low |
| frame_n | input | 1 | Bus frame, active low |
| irdy_n | input | 1 | Bus initiator ready, active low |

## Verification
The bench builds the arbiter with the default `N_EXT = 6`, which gives seven agents. Because seven is not a power of two, the round-robin sweep must wrap from index 6 back to 0 through the subtract-on-overflow path rather than a natural counter roll-over. The six request pins also cover the pass-through layout, with one driven request and five lines held high. A resting grant, a held grant on a busy bus, and a release-driven hand-off are each reached from directed request patterns.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam logic [2:0] CODE_PASS  = 3'd3;
    localparam logic [2:0] CODE_FIXED = 3'd4;
    localparam logic [2:0] CODE_ROUND = 3'd5;
    localparam logic [2:0] CODE_IDLE  = 3'd7;

    typedef struct packed {
        logic pass;
        logic fixed;
        logic round;
    } mode_sel_t;

    typedef struct packed {
        logic [2:0] code;
        logic       locked;
    } latch_st_t;

    function automatic mode_sel_t decode_mode(input logic [2:0] code);
        mode_sel_t s;
        s.pass  = (code == CODE_PASS);
        s.fixed = (code == CODE_FIXED);
        s.round = (code == CODE_ROUND);
        return s;
    endfunction

endpackage

// File: rtl/arb_mode_latch.sv
module arb_mode_latch
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_cfg,
    output mode_sel_t  sel
);

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.locked) begin
            st_d.code   = mode_cfg;
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code   <= CODE_IDLE;
            st_q.locked <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel = decode_mode(st_q.code);

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int NA   = 7,
    parameter int IDXW = $clog2(NA)
) (
    input  logic [NA-1:0]   req,
    input  logic [IDXW-1:0] base,
    input  logic            round,
    output logic            found,
    output logic [IDXW-1:0] idx
);

    localparam logic [IDXW:0] NA_W = (IDXW+1)'(NA);

    logic [IDXW:0] pos;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        pos   = '0;
        for (int k = 0; k < NA; k++) begin
            if (round) begin
                pos = {1'b0, base} + (IDXW+1)'(k + 1);
                if (pos >= NA_W) begin
                    pos = pos - NA_W;
                end
            end else begin
                pos = (IDXW+1)'(k);
            end
            if (!found && req[pos[IDXW-1:0]]) begin
                found = 1'b1;
                idx   = pos[IDXW-1:0];
            end
        end
    end

endmodule

// File: rtl/arb_core.sv
module arb_core
    import arb_pkg::*;
#(
    parameter int NA   = 7,
    parameter int IDXW = $clog2(NA)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  mode_sel_t       sel,
    input  logic [NA-1:0]   req_raw,
    input  logic            idle_raw,
    output logic [NA-1:0]   req_q,
    output logic            idle_q,
    output logic [NA-1:0]   gnt_q
);

    typedef struct packed {
        logic [NA-1:0]   req;
        logic            idle;
        logic [NA-1:0]   gnt;
        logic [IDXW-1:0] owner;
        logic [IDXW-1:0] last;
    } core_st_t;

    localparam logic [NA-1:0] ONE_HOT0 = {{(NA-1){1'b0}}, 1'b1};

    core_st_t        st_d, st_q;
    logic            pick_found;
    logic [IDXW-1:0] pick_idx;
    logic            arb_on;
    logic            owner_wants;
    logic            rearb;

    arb_pick #(.NA(NA), .IDXW(IDXW)) u_pick (
        .req   (st_q.req),
        .base  (st_q.last),
        .round (sel.round),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.req    = req_raw;
        st_d.idle   = idle_raw;
        arb_on      = sel.fixed | sel.round;
        owner_wants = st_q.req[st_q.owner];
        rearb       = st_q.idle | ~owner_wants | ~(|st_q.gnt);
        if (!arb_on) begin
            st_d.gnt   = '0;
            st_d.owner = '0;
        end else if (rearb) begin
            if (pick_found) begin
                st_d.owner = pick_idx;
                st_d.last  = pick_idx;
            end else begin
                st_d.owner = '0;
            end
            st_d.gnt = ONE_HOT0 << st_d.owner;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.req   <= '0;
            st_q.idle  <= 1'b1;
            st_q.gnt   <= '0;
            st_q.owner <= '0;
            st_q.last  <= IDXW'(NA - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign req_q  = st_q.req;
    assign idle_q = st_q.idle;
    assign gnt_q  = st_q.gnt;

endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
    import arb_pkg::*;
#(
    parameter int N_EXT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_cfg,
    input  logic             own_req_n,
    output logic             own_gnt_n,
    input  logic [N_EXT-1:0] req_n_in,
    output logic [N_EXT-1:0] req_n_out,
    output logic [N_EXT-1:0] req_n_oe,
    output logic [N_EXT-1:0] gnt_n,
    input  logic             ext_gnt_n,
    input  logic             frame_n,
    input  logic             irdy_n
);

    localparam int NA   = N_EXT + 1;
    localparam int IDXW = $clog2(NA);

    mode_sel_t     sel;
    logic [NA-1:0] req_raw;
    logic [NA-1:0] req_q_vec;
    logic [NA-1:0] gnt_q_vec;
    logic          idle_q;

    arb_mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_cfg (mode_cfg),
        .sel      (sel)
    );

    assign req_raw = {~req_n_in, ~own_req_n};

    arb_core #(.NA(NA), .IDXW(IDXW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .req_raw  (req_raw),
        .idle_raw (frame_n & irdy_n),
        .req_q    (req_q_vec),
        .idle_q   (idle_q),
        .gnt_q    (gnt_q_vec)
    );

    always_comb begin
        req_n_out = '1;
        req_n_oe  = '0;
        gnt_n     = ~gnt_q_vec[NA-1:1];
        own_gnt_n = ~gnt_q_vec[0];
        if (sel.pass) begin
            req_n_oe     = '1;
            req_n_out[0] = own_req_n;
            gnt_n        = '1;
            own_gnt_n    = ext_gnt_n;
        end
    end

endmodule

// File: rtl/arb_checker.sv
module arb_checker
    import arb_pkg::*;
#(
    parameter int N_EXT = 6
) (
    input logic             clk,
    input logic             rst_n,
    input mode_sel_t        sel,
    input logic [N_EXT:0]   req_q,
    input logic             idle_q,
    input logic [N_EXT:0]   gnt_q,
    input logic [N_EXT-1:0] gnt_n,
    input logic             own_gnt_n,
    input logic [N_EXT-1:0] req_n_oe,
    input logic [N_EXT-1:0] req_n_out
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert ((&gnt_n) && own_gnt_n && (req_n_oe == '0))
                else $error("grant or drive active during reset");
        end
    end

    // R3
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~gnt_n, ~own_gnt_n}) <= 1);

    // R2
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|sel) |=> $stable(sel));

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel.fixed || sel.round) && !idle_q && ((gnt_q & req_q) != '0))
        |=> $stable(gnt_q));

    // R8
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel.fixed || sel.round) && (req_q == '0)) |=> gnt_q[0]);

    // R9
    pass_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel.pass |-> ((&req_n_oe) && (&gnt_n) && (&req_n_out[N_EXT-1:1])));

    // R10
    off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> ((&gnt_n) && own_gnt_n && (req_n_oe == '0)));

endmodule

bind bus_grant_arbiter arb_checker #(.N_EXT(N_EXT)) u_arb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .req_q     (req_q_vec),
    .idle_q    (idle_q),
    .gnt_q     (gnt_q_vec),
    .gnt_n     (gnt_n),
    .own_gnt_n (own_gnt_n),
    .req_n_oe  (req_n_oe),
    .req_n_out (req_n_out)
);

// File: tb/tb_bus_grant_arbiter.sv
`timescale 1ns/1ps
module tb_bus_grant_arbiter;

    localparam int N_EXT = 6;
    localparam int NA    = N_EXT + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       mode_cfg = 3'd4;
    logic             own_req_n = 1'b1;
    logic             own_gnt_n;
    logic [N_EXT-1:0] req_n_in = '1;
    logic [N_EXT-1:0] req_n_out;
    logic [N_EXT-1:0] req_n_oe;
    logic [N_EXT-1:0] gnt_n;
    logic             ext_gnt_n = 1'b1;
    logic             frame_n = 1'b1;
    logic             irdy_n = 1'b1;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #4 clk = ~clk;

    bus_grant_arbiter #(.N_EXT(N_EXT)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_cfg  (mode_cfg),
        .own_req_n (own_req_n),
        .own_gnt_n (own_gnt_n),
        .req_n_in  (req_n_in),
        .req_n_out (req_n_out),
        .req_n_oe  (req_n_oe),
        .gnt_n     (gnt_n),
        .ext_gnt_n (ext_gnt_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n)
    );

    function automatic logic [NA-1:0] grants();
        return ~{gnt_n, own_gnt_n};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_agent(input string tag, input int k);
        check(tag, 32'(grants()), 32'(1) << k);
        check("R3 single grant", 32'($countones(grants()) <= 1), 32'd1);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic reset_with(input logic [2:0] code);
        @(negedge clk);
        rst_n = 1'b0;
        own_req_n = 1'b1; req_n_in = '1; ext_gnt_n = 1'b1;
        frame_n = 1'b1; irdy_n = 1'b1;
        mode_cfg = code;
        repeat (2) @(negedge clk);
        check("R1 grants during reset", 32'({gnt_n, own_gnt_n}), 32'({NA{1'b1}}));
        check("R1 no drive during reset", 32'(req_n_oe), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_fixed();
        reset_with(3'd4);
        settle();
        expect_agent("R8 park when idle", 0);
        req_n_in = ~6'b100100;
        settle();
        expect_agent("R5 line2 beats line5", 3);
        req_n_in = ~6'b100101;
        settle();
        expect_agent("R5 line0 beats others", 1);
        own_req_n = 1'b0;
        settle();
        expect_agent("R5 internal highest", 0);
        check("R10 inputs in arb mode", 32'(req_n_oe), 32'd0);
    endtask

    task automatic t_handoff();
        reset_with(3'd4);
        frame_n = 1'b0;
        req_n_in = ~6'b010000;
        settle();
        expect_agent("R7 first grant from park", 5);
        req_n_in = ~6'b010010;
        settle();
        @(negedge clk);
        expect_agent("R7 hold while busy", 5);
        frame_n = 1'b1; irdy_n = 1'b1;
        settle();
        expect_agent("R7 move on idle", 2);
        req_n_in = ~6'b010011;
        @(negedge clk);
        expect_agent("R4 no change after one edge", 2);
        @(negedge clk);
        expect_agent("R4 change after two edges", 1);
        frame_n = 1'b0; irdy_n = 1'b0;
        req_n_in = ~6'b001010;
        settle();
        expect_agent("R7 move on owner release", 2);
        req_n_in = '1;
        settle();
        expect_agent("R8 park on busy bus", 0);
    endtask

    task automatic t_round();
        reset_with(3'd5);
        own_req_n = 1'b0;
        req_n_in = '0;
        settle();
        for (int i = 0; i < 10; i++) begin
            expect_agent("R6 rotation", i % NA);
            @(negedge clk);
        end
        req_n_in = '1; own_req_n = 1'b1;
        settle();
        expect_agent("R8 park in round robin", 0);
    endtask

    task automatic t_pass();
        reset_with(3'd3);
        req_n_in = '0;
        settle();
        check("R9 all pins driven", 32'(req_n_oe), 32'h3f);
        check("R9 idle request out", 32'(req_n_out), 32'h3f);
        check("R9 ext grants high", 32'(gnt_n), 32'h3f);
        own_req_n = 1'b0;
        #1;
        check("R9 request forwarded", 32'(req_n_out), 32'h3e);
        ext_gnt_n = 1'b0;
        #1;
        check("R9 grant follows outside", 32'(own_gnt_n), 32'd0);
        ext_gnt_n = 1'b1;
        #1;
        check("R9 grant released", 32'(own_gnt_n), 32'd1);
    endtask

    task automatic t_off(input logic [2:0] code);
        reset_with(code);
        own_req_n = 1'b0;
        req_n_in = '0;
        repeat (4) @(negedge clk);
        check("R10 no grant in off code", 32'({gnt_n, own_gnt_n}), 32'h7f);
        check("R10 no drive in off code", 32'(req_n_oe), 32'd0);
    endtask

    task automatic t_lock();
        reset_with(3'd4);
        @(negedge clk);
        mode_cfg = 3'd3;
        req_n_in = ~6'b000100;
        settle();
        expect_agent("R2 later code ignored", 3);
        check("R2 pins stay inputs", 32'(req_n_oe), 32'd0);
    endtask

    initial begin
        t_fixed();
        t_handoff();
        t_round();
        t_pass();
        t_off(3'd6);
        t_off(3'd7);
        t_off(3'd1);
        t_lock();
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog R1-R10 run actual=hung expected=done");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule